// File: doc/BRIEF.md
# Event Time-Stamp Timer

This block is a free-running timer whose count can be frozen into a register when an outside event arrives. The event comes from one of two places: a package pin or an internal comparator result bit. A control bit picks which one. The chosen level is synchronised to the clock and can be passed through a majority-free debounce filter. It then reaches an edge detector whose polarity software chooses. On a qualifying edge, with capture enabled, the current count is copied and the capture flag rises.

No private capture register exists. The time-stamp lands in the two compare registers. In byte mode only compare A is overwritten, and compare B stays a normal compare. In word mode compare A receives the low byte and compare B the high byte, and both compare outputs are forced inactive. Software reaches the 16-bit counter through an 8-bit port. A shared holding byte makes the two halves coherent. A 3-bit clock-select field stops the counter or makes it advance on a power-of-two division of the clock.

Top module: `tcap_timer`

## Requirements
- R1: With clock select (CTRL[2:0], address 0) equal to 0 the counter holds its value, and software can still read and write it.
- R2: A counter write (low byte at address 2) in the same cycle as an increment wins: the written value is what the counter holds afterwards.
- R3: The overflow flag (FLAGS bit 0, address 1, output `ovf_flag`) sets on the increment that wraps the counter past its top: 255 in byte mode (CTRL[3]=0), 65535 in word mode (CTRL[3]=1).
- R4: CTRL[7]=0 takes events from `cap_pin` and CTRL[7]=1 takes them from `cmp_out`. The source not selected has no effect.
- R5: With capture enabled (CTRL[4]=1), a capture happens only on the edge chosen by CTRL[5] (1 rising, 0 falling). The capture copies the count and sets the capture flag (FLAGS bit 1, output `cap_flag`). With CTRL[4]=0 there is no capture.
- R6: In byte capture mode only compare A (address 4) takes the count. Compare B (address 5) keeps its value, and `hit_b` still goes high while the counter low byte equals it. `hit_a` stays low.
- R7: In word capture mode compare A takes count bits 7:0 and compare B takes bits 15:8. `hit_a` and `hit_b` both stay low.
- R8: Without the filter (CTRL[6]=0) the captured count is the one held three clocks after the input changes. With the filter on, a new level is accepted only after four equal samples, which adds exactly four clocks. A pulse of two clocks is rejected.
- R9: Reading counter low (address 2) copies the counter high byte into a holding byte, and reading address 3 returns that holding byte. Writing address 3 fills the holding byte, and the next low-byte write loads both bytes in word mode. In word capture mode, reading compare A copies compare B into the holding byte, and address 5 then returns it.
- R10: Writing a 1 to a flag bit clears it, and writing 0 leaves it alone. A set event in the same cycle as the clear wins.
- R11: A clock select n from 1 to 7 makes the counter advance once every 2^(n-1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (for holding-byte side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| cap_pin | input | 1 | External event pin, asynchronous |
| cmp_out | input | 1 | Comparator result bit, asynchronous |
| ovf_flag | output | 1 | Overflow flag |
| cap_flag | output | 1 | Capture flag |
| hit_a | output | 1 | Counter low byte equals compare A, compare A not in capture use |
| hit_b | output | 1 | Counter low byte equals compare B, compare B not in capture use |

## Verification
The assertions assume the following about the inputs:
- `bus_wr` and `bus_rd` are single-cycle strobes that are never raised together.
- Only the defined addresses are used.
- Mode bits do not change while an event is moving through the synchroniser and filter.

The directed stimulus keeps to these rules. Each register access spans one clock edge with a single strobe. The control word changes only while the selected event level has been steady for several clocks. Both event inputs are changed only on the falling clock edge.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

   typedef enum logic [2:0] {
      RA_CTRL = 3'd0,
      RA_FLAG = 3'd1,
      RA_CNTL = 3'd2,
      RA_CNTH = 3'd3,
      RA_CMPA = 3'd4,
      RA_CMPB = 3'd5
   } tcap_addr_e;

   // control byte, most significant field first
   typedef struct packed {
      logic       src_cmp;
      logic       nc_en;
      logic       rise;
      logic       cap_en;
      logic       wide;
      logic [2:0] cs;
   } tcap_ctrl_t;

   localparam int FLAG_OVF = 0;
   localparam int FLAG_CAP = 1;

endpackage

// File: rtl/tcap_sync_filt.sv
module tcap_sync_filt #(
   parameter int SYNC_N = 2,
   parameter int NC_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic cmp_i,
   input  logic src_cmp_i,
   input  logic nc_en_i,
   input  logic rise_i,
   output logic edge_o
);

   generate
      if (SYNC_N < 2) begin : g_bad_sync
         $error("tcap_sync_filt: SYNC_N must be at least 2");
      end
      if (NC_LEN < 2) begin : g_bad_nc
         $error("tcap_sync_filt: NC_LEN must be at least 2");
      end
   endgenerate

   logic              raw;
   logic [SYNC_N-1:0] sync_q;
   logic [NC_LEN-1:0] hist_q;
   logic              filt_q, filt_d, prev_q;

   assign raw = src_cmp_i ? cmp_i : pin_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_N-2:0], raw};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= {hist_q[NC_LEN-2:0], sync_q[SYNC_N-1]};
   end

   always_comb begin
      if (!nc_en_i)       filt_d = sync_q[SYNC_N-1];
      else if (&hist_q)   filt_d = 1'b1;
      else if (~|hist_q)  filt_d = 1'b0;
      else                filt_d = filt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         filt_q <= filt_d;
         prev_q <= filt_q;
      end
   end

   assign edge_o = rise_i ? (filt_q & ~prev_q) : (~filt_q & prev_q);

   // R8: with the filter on, an accepted rise follows a full run of highs
   p_nc_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(filt_q) && $past(nc_en_i)) |-> ($past(hist_q) == {NC_LEN{1'b1}}));

   // R8: with the filter on, an accepted fall follows a full run of lows
   p_nc_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(filt_q) && $past(nc_en_i)) |-> ($past(hist_q) == {NC_LEN{1'b0}}));

endmodule

// File: rtl/tcap_count.sv
module tcap_count #(
   parameter int CNT_W = 16,
   parameter int LOW_W = 8,
   parameter int PRE_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cs_i,
   input  logic             wide_i,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] ld_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);

   localparam int HI_W = CNT_W - LOW_W;

   generate
      if (PRE_W < 6) begin : g_bad_pre
         $error("tcap_count: PRE_W must cover a divide by 64");
      end
      if (HI_W < 1) begin : g_bad_w
         $error("tcap_count: CNT_W must exceed LOW_W");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q, mask;
   logic [CNT_W-1:0] cnt_q;
   logic             tick, at_max;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + PRE_W'(1);
   end

   always_comb begin
      mask = '0;
      if (cs_i != 3'd0) mask = (PRE_W'(1) << (cs_i - 3'd1)) - PRE_W'(1);
   end

   assign tick   = (cs_i != 3'd0) && ((pre_q & mask) == mask);
   assign at_max = wide_i ? (&cnt_q) : (&cnt_q[LOW_W-1:0]);
   assign wrap_o = tick && at_max && !ld_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (ld_i)   cnt_q <= ld_val_i;
      else if (tick) begin
         if (wide_i) cnt_q <= cnt_q + CNT_W'(1);
         else        cnt_q <= {{HI_W{1'b0}}, cnt_q[LOW_W-1:0] + LOW_W'(1)};
      end
   end

   assign cnt_o = cnt_q;

   // R1: stopped clock select and no load keeps the count
   p_stop_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_i == 3'd0 && !ld_i) |=> $stable(cnt_q));

   // R2: a load always lands, whatever the prescaler does
   p_load_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> (cnt_q == $past(ld_val_i)));

   // R3: a wrap leaves the counter at zero
   p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (cnt_q == '0));

endmodule

// File: rtl/tcap_timer.sv
module tcap_timer
   import tcap_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int CNT_W  = 16,
   parameter int PRE_W  = 6,
   parameter int SYNC_N = 2,
   parameter int NC_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic             cap_pin,
   input  logic             cmp_out,
   output logic             ovf_flag,
   output logic             cap_flag,
   output logic             hit_a,
   output logic             hit_b
);

   localparam int HI_W = CNT_W - BUS_W;

   generate
      if (BUS_W != 8) begin : g_bad_bus
         $error("tcap_timer: control layout needs an 8-bit bus");
      end
      if (CNT_W != 2 * BUS_W) begin : g_bad_cnt
         $error("tcap_timer: counter must be two bus bytes wide");
      end
   endgenerate

   tcap_ctrl_t       ctrl_q;
   tcap_addr_e       addr;
   logic [BUS_W-1:0] temp_q, cmpa_q, cmpb_q;
   logic [CNT_W-1:0] cnt, ld_val;
   logic             ovf_q, capf_q;
   logic             wrap, edge_evt, cap_hit, wide_cap;
   logic             wr_ctrl, wr_flag, wr_cntl, wr_cnth, wr_cmpa, wr_cmpb;
   logic             rd_cntl, rd_cmpa;

   assign addr    = tcap_addr_e'(bus_addr);
   assign wr_ctrl = bus_wr && addr == RA_CTRL;
   assign wr_flag = bus_wr && addr == RA_FLAG;
   assign wr_cntl = bus_wr && addr == RA_CNTL;
   assign wr_cnth = bus_wr && addr == RA_CNTH;
   assign wr_cmpa = bus_wr && addr == RA_CMPA;
   assign wr_cmpb = bus_wr && addr == RA_CMPB;
   assign rd_cntl = bus_rd && addr == RA_CNTL;
   assign rd_cmpa = bus_rd && addr == RA_CMPA;

   assign wide_cap = ctrl_q.cap_en && ctrl_q.wide;
   assign ld_val   = ctrl_q.wide ? {temp_q, bus_wdata} : {{HI_W{1'b0}}, bus_wdata};

   tcap_count #(.CNT_W(CNT_W), .LOW_W(BUS_W), .PRE_W(PRE_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_i     (ctrl_q.cs),
      .wide_i   (ctrl_q.wide),
      .ld_i     (wr_cntl),
      .ld_val_i (ld_val),
      .cnt_o    (cnt),
      .wrap_o   (wrap)
   );

   tcap_sync_filt #(.SYNC_N(SYNC_N), .NC_LEN(NC_LEN)) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (cap_pin),
      .cmp_i     (cmp_out),
      .src_cmp_i (ctrl_q.src_cmp),
      .nc_en_i   (ctrl_q.nc_en),
      .rise_i    (ctrl_q.rise),
      .edge_o    (edge_evt)
   );

   assign cap_hit = edge_evt && ctrl_q.cap_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= tcap_ctrl_t'(bus_wdata);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   temp_q <= '0;
      else if (wr_cnth)             temp_q <= bus_wdata;
      else if (rd_cntl)             temp_q <= cnt[CNT_W-1:BUS_W];
      else if (rd_cmpa && wide_cap) temp_q <= cmpb_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmpa_q <= '0;
         cmpb_q <= '0;
      end else begin
         if (cap_hit)      cmpa_q <= cnt[BUS_W-1:0];
         else if (wr_cmpa) cmpa_q <= bus_wdata;
         if (cap_hit && ctrl_q.wide) cmpb_q <= cnt[CNT_W-1:BUS_W];
         else if (wr_cmpb)           cmpb_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q  <= 1'b0;
         capf_q <= 1'b0;
      end else begin
         if (wrap)                                 ovf_q <= 1'b1;
         else if (wr_flag && bus_wdata[FLAG_OVF])  ovf_q <= 1'b0;
         if (cap_hit)                              capf_q <= 1'b1;
         else if (wr_flag && bus_wdata[FLAG_CAP])  capf_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (addr)
         RA_CTRL: bus_rdata = ctrl_q;
         RA_FLAG: begin
            bus_rdata[FLAG_OVF] = ovf_q;
            bus_rdata[FLAG_CAP] = capf_q;
         end
         RA_CNTL: bus_rdata = cnt[BUS_W-1:0];
         RA_CNTH: bus_rdata = temp_q;
         RA_CMPA: bus_rdata = cmpa_q;
         RA_CMPB: bus_rdata = wide_cap ? temp_q : cmpb_q;
         default: bus_rdata = '0;
      endcase
   end

   assign ovf_flag = ovf_q;
   assign cap_flag = capf_q;
   assign hit_a    = !ctrl_q.cap_en && (cnt[BUS_W-1:0] == cmpa_q);
   assign hit_b    = !wide_cap && (cnt[BUS_W-1:0] == cmpb_q);

   // R3: a wrap always raises the overflow flag, even against a clear
   p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ovf_q);

   // R5 / R10: a capture always raises the capture flag
   p_cap_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit |=> capf_q);

   // R5: capture writes the low count byte into compare A
   p_cap_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit |=> (cmpa_q == $past(cnt[BUS_W-1:0])));

   // R6: byte capture leaves compare B alone
   p_cmpb_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_hit && !ctrl_q.wide && !wr_cmpb) |=> $stable(cmpb_q));

   // R7: word capture puts the high count byte in compare B
   p_cap_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_hit && ctrl_q.wide) |=> (cmpb_q == $past(cnt[CNT_W-1:BUS_W])));

   // R10: a clear with no set event drops the flag
   p_ovf_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && bus_wdata[FLAG_OVF] && !wrap) |=> !ovf_q);

endmodule

// File: tb/tcap_timer_test.sv
module tcap_timer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cap_pin = 1'b0;
   logic       cmp_out = 1'b0;
   logic       ovf_flag, cap_flag, hit_a, hit_b;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   localparam logic [2:0] A_CTRL = 3'd0, A_FLAG = 3'd1, A_CNTL = 3'd2,
                          A_CNTH = 3'd3, A_CMPA = 3'd4, A_CMPB = 3'd5;

   always #10 clk = ~clk;

   tcap_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cap_pin(cap_pin), .cmp_out(cmp_out), .ovf_flag(ovf_flag),
      .cap_flag(cap_flag), .hit_a(hit_a), .hit_b(hit_b)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); @(negedge clk);
      end
   endtask

   task automatic t_reset;
      logic [7:0] d;
      rd(A_CTRL, d); chk("reset ctrl", d, 8'h00);
      rd(A_FLAG, d); chk("reset flags", d, 8'h00);
      chk("reset ovf_flag", ovf_flag, 1'b0);
      chk("reset cap_flag", cap_flag, 1'b0);
      rd(A_CNTL, d); chk("reset count", d, 8'h00);
   endtask

   task automatic t_stop_r1;
      logic [7:0] d;
      wr(A_CTRL, 8'h08);
      wr(A_CNTH, 8'h12);
      wr(A_CNTL, 8'h34);
      idle(10);
      rd(A_CNTL, d); chk("R1 stopped low", d, 8'h34);
      rd(A_CNTH, d); chk("R1 stopped high via R9 holding", d, 8'h12);
   endtask

   task automatic t_atomic_r9;
      logic [7:0] d;
      wr(A_CNTH, 8'h12);
      wr(A_CNTL, 8'hFF);
      rd(A_CNTL, d); chk("R9 low byte", d, 8'hFF);
      wr(A_CTRL, 8'h09);
      idle(4);
      wr(A_CTRL, 8'h08);
      rd(A_CNTH, d); chk("R9 high byte latched", d, 8'h12);
      rd(A_CNTL, d); chk("R9 count moved", d, 8'h04);
      rd(A_CNTH, d); chk("R9 new high latched", d, 8'h13);
   endtask

   task automatic t_prio_r2;
      logic [7:0] d;
      wr(A_CTRL, 8'h01);
      idle(3);
      wr(A_CNTL, 8'h40);
      rd(A_CNTL, d); chk("R2 write beats increment", d, 8'h40);
   endtask

   task automatic t_ovf_r3_r10;
      wr(A_FLAG, 8'h03);
      wr(A_CNTL, 8'hFF);
      chk("R3 no overflow yet", ovf_flag, 1'b0);
      wr(A_FLAG, 8'h01);
      chk("R10 set beats clear", ovf_flag, 1'b1);
      wr(A_FLAG, 8'h00);
      chk("R10 zero write keeps", ovf_flag, 1'b1);
      wr(A_FLAG, 8'h01);
      chk("R10 one write clears", ovf_flag, 1'b0);
      wr(A_CTRL, 8'h09);
      wr(A_CNTH, 8'hFF);
      wr(A_CNTL, 8'hFE);
      chk("R3 word at FFFE", ovf_flag, 1'b0);
      idle(1);
      chk("R3 word at FFFF", ovf_flag, 1'b0);
      idle(1);
      chk("R3 word wrap", ovf_flag, 1'b1);
      wr(A_CTRL, 8'h00);
      wr(A_FLAG, 8'h01);
   endtask

   task automatic t_div_r11;
      logic [7:0] a, b;
      wr(A_CTRL, 8'h01);
      rd(A_CNTL, a); idle(7); rd(A_CNTL, b);
      chk("R11 cs1", 8'(b - a), 8'd8);
      wr(A_CTRL, 8'h02);
      rd(A_CNTL, a); idle(7); rd(A_CNTL, b);
      chk("R11 cs2", 8'(b - a), 8'd4);
      wr(A_CTRL, 8'h03);
      rd(A_CNTL, a); idle(7); rd(A_CNTL, b);
      chk("R11 cs3", 8'(b - a), 8'd2);
      wr(A_CTRL, 8'h00);
   endtask

   task automatic t_byte_cap_r5_r6;
      logic [7:0] d;
      wr(A_CNTL, 8'h5A);
      wr(A_CMPA, 8'h11);
      wr(A_CMPB, 8'h77);
      wr(A_CTRL, 8'h20);
      cap_pin = 1'b1; idle(6);
      chk("R5 disabled no capture", cap_flag, 1'b0);
      cap_pin = 1'b0; idle(6);
      wr(A_CTRL, 8'h30);
      wr(A_FLAG, 8'h02);
      cap_pin = 1'b1; idle(6);
      chk("R5 rising capture flag", cap_flag, 1'b1);
      rd(A_CMPA, d); chk("R5 count in compare A", d, 8'h5A);
      rd(A_CMPB, d); chk("R6 compare B kept", d, 8'h77);
      wr(A_CMPB, 8'h5A);
      chk("R6 compare B still hits", hit_b, 1'b1);
      chk("R6 compare A silent", hit_a, 1'b0);
      wr(A_FLAG, 8'h02);
      cap_pin = 1'b0; idle(6);
      chk("R5 falling ignored", cap_flag, 1'b0);
      wr(A_CTRL, 8'h10);
      wr(A_CNTL, 8'h33);
      cap_pin = 1'b1; idle(6);
      chk("R5 rising ignored", cap_flag, 1'b0);
      cap_pin = 1'b0; idle(6);
      chk("R5 falling capture", cap_flag, 1'b1);
      rd(A_CMPA, d); chk("R5 falling value", d, 8'h33);
   endtask

   task automatic t_src_r4;
      logic [7:0] d;
      wr(A_CTRL, 8'hB0);
      wr(A_CNTL, 8'h66);
      wr(A_FLAG, 8'h02);
      cap_pin = 1'b1; idle(6);
      chk("R4 pin ignored", cap_flag, 1'b0);
      cmp_out = 1'b1; idle(6);
      chk("R4 comparator capture", cap_flag, 1'b1);
      rd(A_CMPA, d); chk("R4 comparator value", d, 8'h66);
      cap_pin = 1'b0; idle(6);
   endtask

   task automatic t_word_r7;
      logic [7:0] d;
      wr(A_CTRL, 8'h08);
      wr(A_CNTH, 8'hAB);
      wr(A_CNTL, 8'hCD);
      wr(A_CMPA, 8'h00);
      wr(A_CMPB, 8'h00);
      wr(A_CTRL, 8'h38);
      wr(A_FLAG, 8'h02);
      cap_pin = 1'b1; idle(6);
      chk("R7 word capture flag", cap_flag, 1'b1);
      rd(A_CMPA, d); chk("R7 low byte in A", d, 8'hCD);
      rd(A_CMPB, d); chk("R7 high byte in B via R9", d, 8'hAB);
      chk("R7 hit_a off", hit_a, 1'b0);
      wr(A_CMPB, 8'hCD);
      chk("R7 hit_b off", hit_b, 1'b0);
      cap_pin = 1'b0; idle(6);
   endtask

   task automatic t_latency_r8;
      logic [7:0] d;
      wr(A_CTRL, 8'h30);
      wr(A_CNTL, 8'h10);
      wr(A_CTRL, 8'h31);
      cap_pin = 1'b1; idle(10);
      wr(A_CTRL, 8'h30);
      rd(A_CMPA, d); chk("R8 unfiltered latency", d, 8'h13);
      cap_pin = 1'b0;
      wr(A_CTRL, 8'h70); idle(10);
      wr(A_FLAG, 8'h02);
      cap_pin = 1'b1; idle(2); cap_pin = 1'b0; idle(12);
      chk("R8 short pulse rejected", cap_flag, 1'b0);
      wr(A_CNTL, 8'h10);
      wr(A_CTRL, 8'h71);
      cap_pin = 1'b1; idle(12);
      wr(A_CTRL, 8'h70);
      rd(A_CMPA, d); chk("R8 filtered latency", d, 8'h17);
      chk("R8 filtered flag", cap_flag, 1'b1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_stop_r1;
      t_atomic_r9;
      t_prio_r2;
      t_ovf_r3_r10;
      t_div_r11;
      t_byte_cap_r5_r6;
      t_src_r4;
      t_word_r7;
      t_latency_r8;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule